// File: doc/BRIEF.md
# Temperature Conversion Request Sequencer

This block decides when the temperature sensor and the oscillator compensation datapath run. A free-running schedule counts one-second ticks and launches a conversion every `PERIOD_S` seconds (64 by default). Software can also ask for a conversion at any time by writing a one to the request bit. That request is taken only when nothing is running. The block drives a one-cycle start pulse to the datapath and waits for its done input.

Two status bits are visible to software. The request bit `conv_bit` reads as one from an accepted write until the conversion it started completes. The busy bit `busy_bit` covers periodic conversions from their start pulse onward. For a software request, `busy_bit` comes up only after a programmable settling delay of `BSY_DELAY_CYC` clock cycles, which is about 2 ms in a real system. A software request never moves the phase of the periodic schedule. If a periodic slot falls due while a software conversion is running, that slot is held and launched as soon as the running conversion reports done.

All pins are plain control and status signals. There is no data stream and no back-pressure.

Top module: `tconv_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `conv_start`, `conv_bit` and `busy_bit` are all 0.
- R2: Every `PERIOD_S`-th `sec_tick` pulse after reset (default 64) launches a periodic conversion. In the cycle after that tick, `conv_start` is 1 and `busy_bit` is 1, while `conv_bit` stays 0.
- R3: A `conv_wr` pulse while idle is accepted. In the next cycle `conv_start` is 1 and `conv_bit` is 1.
- R4: A `conv_wr` pulse while a conversion is in progress has no effect. No start pulse is issued, `conv_bit` keeps its value, and `conv_bit` does not become 1 during a periodic conversion.
- R5: After an accepted write, `busy_bit` stays 0 for `BSY_DELAY_CYC` cycles, counted from the cycle in which `conv_start` is high. It becomes 1 in the `BSY_DELAY_CYC`-th cycle after that cycle, unless done arrives first.
- R6: A `conv_done` pulse during a conversion clears `conv_bit` and `busy_bit` in the next cycle, unless a held periodic slot launches at that point (see R8).
- R7: A software conversion does not shift the periodic schedule. The next periodic start still follows the `PERIOD_S`-th tick counted from the previous period boundary.
- R8: A periodic slot that falls due during a software conversion does not start at once. In the cycle after `conv_done`, `conv_start` is 1, `busy_bit` is 1 and `conv_bit` is 0.
- R9: A `conv_done` pulse while idle is ignored. It produces no start and changes no status bit.
- R10: `conv_start` is high for exactly one cycle per launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| sec_tick | input | 1 | One-cycle pulse once per second |
| conv_wr | input | 1 | One-cycle strobe: software writes 1 to the request bit |
| conv_done | input | 1 | One-cycle pulse from the datapath when a conversion finishes |
| conv_start | output | 1 | One-cycle launch pulse to the sensor and compensation datapath |
| conv_bit | output | 1 | Software request bit as read back |
| busy_bit | output | 1 | Busy status bit |

## Verification
Every output is registered. A write, a done pulse or the tick that closes a period shows its result one cycle later. The delayed busy bit shows up `BSY_DELAY_CYC` cycles after the start pulse cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check sees the state after exactly the rising edge that consumed the stimulus. Delayed-busy checks are placed the counted number of steps after acceptance, with the delay parameter shortened to 3.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_USER     = 2'd1,
    SEQ_PERIODIC = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tconv_period_timer.sv
module tconv_period_timer #(
  parameter int PERIOD_S = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  output logic slot_due
);
  localparam int CW = (PERIOD_S > 2) ? $clog2(PERIOD_S) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_S - 1);

  logic [CW-1:0] sec_cnt;

  // Boundary tick: the tick that completes a full period
  assign slot_due = sec_tick && (sec_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_cnt <= '0;
    end else if (sec_tick) begin
      if (sec_cnt == LAST) sec_cnt <= '0;
      else                 sec_cnt <= sec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tconv_busy_delay.sv
module tconv_busy_delay #(
  parameter int BSY_DELAY_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic fire
);
  localparam int DW = $clog2(BSY_DELAY_CYC + 1);
  localparam logic [DW-1:0] LOADV = DW'(BSY_DELAY_CYC);

  logic [DW-1:0] remain;

  // fire in the cycle before the counter empties; consumer registers it
  assign fire = (remain == DW'(1)) && !clear && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= LOADV;
    else if (clear)          remain <= '0;
    else if (remain != '0)   remain <= remain - 1'b1;
  end
endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer
  import tconv_pkg::*;
#(
  parameter int PERIOD_S      = 64,
  parameter int BSY_DELAY_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic conv_wr,
  input  logic conv_done,
  output logic conv_start,
  output logic conv_bit,
  output logic busy_bit
);
  seq_state_e state;
  logic       held_slot;
  logic       slot_due;
  logic       dly_fire;
  logic       want_periodic;
  logic       accept_user;
  logic       user_finish;

  tconv_period_timer #(.PERIOD_S(PERIOD_S)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .slot_due (slot_due)
  );

  assign accept_user   = (state == SEQ_IDLE) && conv_wr;
  assign user_finish   = (state == SEQ_USER) && conv_done;
  assign want_periodic = held_slot || slot_due;

  tconv_busy_delay #(.BSY_DELAY_CYC(BSY_DELAY_CYC)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_user),
    .clear (user_finish),
    .fire  (dly_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      held_slot  <= 1'b0;
      conv_start <= 1'b0;
      conv_bit   <= 1'b0;
      busy_bit   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (conv_wr) begin
            state      <= SEQ_USER;
            conv_bit   <= 1'b1;
            conv_start <= 1'b1;
            held_slot  <= want_periodic;
          end else if (want_periodic) begin
            state      <= SEQ_PERIODIC;
            conv_start <= 1'b1;
            busy_bit   <= 1'b1;
            held_slot  <= 1'b0;
          end
        end
        SEQ_USER: begin
          if (conv_done) begin
            conv_bit <= 1'b0;
            if (want_periodic) begin
              state      <= SEQ_PERIODIC;
              conv_start <= 1'b1;
              busy_bit   <= 1'b1;
              held_slot  <= 1'b0;
            end else begin
              state    <= SEQ_IDLE;
              busy_bit <= 1'b0;
            end
          end else begin
            held_slot <= want_periodic;
            if (dly_fire) busy_bit <= 1'b1;
          end
        end
        SEQ_PERIODIC: begin
          if (conv_done) begin
            if (want_periodic) begin
              conv_start <= 1'b1;
              held_slot  <= 1'b0;
            end else begin
              state    <= SEQ_IDLE;
              busy_bit <= 1'b0;
            end
          end else begin
            held_slot <= want_periodic;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tconv_sequencer_chk.sv
module tconv_sequencer_chk #(
  parameter int BSY_DELAY_CYC = 200000
) (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic conv_wr,
  input logic conv_done,
  input logic conv_start,
  input logic conv_bit,
  input logic busy_bit
);
  AST_REQ_RISE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_bit) |-> conv_start); // R3

  AST_WR_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_bit && conv_wr && !conv_done) |=> (conv_bit && !conv_start)); // R4

  AST_DONE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_bit && conv_done) |=> !conv_bit); // R6

  AST_PERIODIC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !conv_bit) |-> busy_bit); // R2

  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_bit && !busy_bit && !conv_start && conv_done && !conv_wr && !sec_tick)
      |=> (!conv_start && !conv_bit && !busy_bit)); // R9

  generate
    if (BSY_DELAY_CYC > 1) begin : g_late
      AST_BUSY_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_bit) |=> !busy_bit); // R5
    end
  endgenerate
endmodule

bind tconv_sequencer tconv_sequencer_chk #(.BSY_DELAY_CYC(BSY_DELAY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .conv_wr    (conv_wr),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .conv_bit   (conv_bit),
  .busy_bit   (busy_bit)
);

// File: tb/tconv_sequencer_test.sv
module tconv_sequencer_test;
  localparam int PER = 64;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic conv_wr = 1'b0;
  logic conv_done = 1'b0;
  logic conv_start, conv_bit, busy_bit;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tconv_sequencer #(.PERIOD_S(PER), .BSY_DELAY_CYC(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .conv_wr(conv_wr),
    .conv_done(conv_done), .conv_start(conv_start), .conv_bit(conv_bit),
    .busy_bit(busy_bit)
  );

  // {wr, done, exp_start, exp_conv, exp_busy}; ticks held low
  // R3 accept, R4 ignored write, R5 delayed busy, R6 done clear, R9 idle done
  localparam logic [4:0] VEC [14] = '{
    5'b10_110, 5'b00_010, 5'b00_010, 5'b00_011, 5'b10_011,
    5'b01_000, 5'b00_000, 5'b10_110, 5'b01_000, 5'b00_000,
    5'b01_000, 5'b11_110, 5'b10_010, 5'b01_000
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic t, input logic w, input logic d);
    sec_tick = t; conv_wr = w; conv_done = d;
    step();
    sec_tick = 1'b0; conv_wr = 1'b0; conv_done = 1'b0;
  endtask

  // n ticks; returns number of start pulses seen after each
  task automatic ticks(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 1'b0);
      if (conv_start) seen++;
    end
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen;
    @(negedge clk);
    step();
    chk("R1 reset start", conv_start, 1'b0);
    chk("R1 reset conv", conv_bit, 1'b0);
    chk("R1 reset busy", busy_bit, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 post-reset busy", busy_bit, 1'b0);

    for (int k = 0; k < 14; k++) begin
      drive(1'b0, VEC[k][4], VEC[k][3]);
      chk($sformatf("R3/R4/R10 start vec%0d", k), conv_start, VEC[k][2]);
      chk($sformatf("R3/R6/R9 conv vec%0d", k), conv_bit, VEC[k][1]);
      chk($sformatf("R5/R6 busy vec%0d", k), busy_bit, VEC[k][0]);
    end

    // R2: periodic launch on the 64th tick
    ticks(PER - 1, seen);
    chk("R2 no early start", seen != 0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    chk("R2 periodic start", conv_start, 1'b1);
    chk("R2 periodic busy", busy_bit, 1'b1);
    chk("R2 periodic conv low", conv_bit, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    chk("R10 single pulse", conv_start, 1'b0);
    chk("R4 write during periodic", conv_bit, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R6 periodic done busy", busy_bit, 1'b0);

    // R7: user conversion in mid-period keeps the schedule
    ticks(30, seen);
    drive(1'b0, 1'b1, 1'b0);
    chk("R3 mid-period accept", conv_bit, 1'b1);
    for (int i = 0; i < 4; i++) step();
    drive(1'b0, 1'b0, 1'b1);
    chk("R6 user done conv", conv_bit, 1'b0);
    ticks(33, seen);
    chk("R7 no shifted start", seen != 0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    chk("R7 on-schedule start", conv_start, 1'b1);
    drive(1'b0, 1'b0, 1'b1);

    // R8: slot due during user conversion is held
    drive(1'b0, 1'b1, 1'b0);
    ticks(PER, seen);
    chk("R8 held, no start", seen != 0, 1'b0);
    chk("R8 user still running", conv_bit, 1'b1);
    chk("R5 busy after delay", busy_bit, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    chk("R8 start after done", conv_start, 1'b1);
    chk("R8 busy", busy_bit, 1'b1);
    chk("R8 conv cleared", conv_bit, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R6 final done", busy_bit, 1'b0);

    // R1: reset mid-conversion
    drive(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step();
    rst_n = 1'b0;
    step();
    chk("R1 mid reset conv", conv_bit, 1'b0);
    chk("R1 mid reset busy", busy_bit, 1'b0);
    rst_n = 1'b1;
    step();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule